// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable slave that answers a three-wire serial memory protocol: a chip select, a shift clock, a serial data input and a serial data output with its own output enable. It holds a 1 Kbit array in an internal register file. A static width input selects either 64 words of 16 bits or 128 bytes of 8 bits. All three serial inputs are sampled by the system clock and edge-detected. They are never used as a clock.

A host opens a transaction by raising chip select and then clocks in a start bit, a two-bit opcode and an address. A read returns a dummy zero followed by the addressed word. Writes, single-location erases and the two whole-array operations are accepted only after an enable command. Each runs a self-timed programming interval measured in system clocks. During that interval, closing and reopening chip select turns the data output into a busy/ready flag.

Top module: `serial_nvm_slave`

## Requirements
- R1: A frame is decoded on rising shift-clock edges while chip select is high. It is a start bit of 1, then a 2-bit opcode sent MSB first (10 read, 01 write, 11 erase, 00 special group), then an address of 6 bits when `wide_i`=1 or 7 bits when `wide_i`=0, MSB first.
- R2: In the special group, the two most significant address bits choose the command: 11 enable programming, 00 disable programming, 10 erase all, 01 write all. The remaining address bits are clocked in and ignored.
- R3: On a read, the output is driven to 0 at the shift-clock rise that carries the last address bit. Each of the following 16 (wide) or 8 (narrow) rises presents the next data bit, MSB first. The output enable drops at the rise after the last data bit. A read works whether programming is enabled or disabled.
- R4: After reset every array bit is 1 and programming is disabled. While disabled, write, erase, erase-all and write-all leave the array unchanged and start no busy interval. Enable stays set until a disable command or reset.
- R5: Write stores the 16 or 8 received data bits (MSB first). Narrow byte address b holds bits 7:0 of wide word b/2 when b is even and bits 15:8 when b is odd.
- R6: Erase sets the addressed word or byte to all ones. Erase-all sets the whole array to ones.
- R7: Write-all stores the received pattern in every location. In narrow mode every byte receives it.
- R8: A programming command keeps the block busy for `PROG_CYCLES` system clocks after its last bit. If chip select falls and rises during that time, the output is driven 0 while busy and 1 once ready, until chip select falls. A chip-select rise after the interval has ended gives no status, and the output stays released.
- R9: Serial traffic in a chip-select window that opened while busy is ignored.
- R10: The output enable is low whenever chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial shift clock, sampled |
| di_i | input | 1 | Serial data in |
| wide_i | input | 1 | 1 selects 16-bit words, 0 selects bytes |
| sdo_o | output | 1 | Serial data out / busy-ready flag |
| sdo_oe_o | output | 1 | Output enable for the tri-state pad |

## Verification
A wrong frame counter or a stale opcode shows up as read data that is shifted by one position or taken from the wrong address. This appears within the same read, at most 17 shift-clock rises after the fault. A lost or stuck enable latch shows up on the next status window as a missing or extra busy flag. It also shows up on the next read as an unchanged or corrupted location. A wrong busy timer shows as a status window that never reaches ready, or a ready flag seen too early, within one programming interval.

// File: rtl/nvm_pkg.sv
// Shared types for the serial EEPROM model: decoder states and command codes.
package nvm_pkg;

    typedef enum logic [2:0] {
        S_IDLE,   // deselected or waiting for a fresh chip-select rise
        S_START,  // waiting for the start bit
        S_OPC,    // collecting the 2-bit opcode
        S_ADR,    // collecting the address field
        S_DAT,    // collecting write data
        S_RD,     // shifting read data out
        S_STAT,   // presenting busy/ready
        S_DONE    // frame finished, ignore until deselect
    } fsm_state_t;

    localparam logic [1:0] OPC_SPECIAL = 2'b00;
    localparam logic [1:0] OPC_WRITE   = 2'b01;
    localparam logic [1:0] OPC_READ    = 2'b10;
    localparam logic [1:0] OPC_ERASE   = 2'b11;

    localparam logic [1:0] SUB_DISABLE = 2'b00;
    localparam logic [1:0] SUB_FILL    = 2'b01;
    localparam logic [1:0] SUB_CLEAR   = 2'b10;
    localparam logic [1:0] SUB_ENABLE  = 2'b11;

endpackage

// File: rtl/nvm_in_sync.sv
// Input conditioner: brings chip select, shift clock and data into the system
// clock domain with two flops each, then flags chip-select and shift-clock rises.
// Assumes each serial level lasts at least three system clocks.
module nvm_in_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    output logic cs_lvl_o,
    output logic cs_rise_o,
    output logic sk_rise_o,
    output logic di_lvl_o
);

    logic [2:0] meta_q;
    logic [2:0] sync_q;
    logic       cs_prev_q;
    logic       sk_prev_q;

    // Two-stage synchronizer plus previous-value flops for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q    <= '0;
            sync_q    <= '0;
            cs_prev_q <= 1'b0;
            sk_prev_q <= 1'b0;
        end else begin
            meta_q    <= {cs_i, sk_i, di_i};
            sync_q    <= meta_q;
            cs_prev_q <= sync_q[2];
            sk_prev_q <= sync_q[1];
        end
    end

    assign cs_lvl_o  = sync_q[2];
    assign cs_rise_o = sync_q[2] & ~cs_prev_q;
    assign sk_rise_o = sync_q[1] & ~sk_prev_q;
    assign di_lvl_o  = sync_q[0];

endmodule

// File: rtl/nvm_prog_timer.sv
// Self-timed programming interval: a start pulse loads a down-counter and the
// block reports busy until it reaches zero. Assumes start never arrives while busy.
module nvm_prog_timer #(
    parameter int CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] left_q;

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (start_i) begin
            left_q <= CW'(CYCLES);
        end else if (left_q != '0) begin
            left_q <= left_q - CW'(1);
        end
    end

    assign busy_o = (left_q != '0);

endmodule

// File: rtl/nvm_array.sv
// Register-file storage: WORDS entries of WIDE_W bits, with byte access in
// narrow mode (odd byte = upper half). One write port that can hit a single
// location or every location; one combinational read port.
module nvm_array #(
    parameter int WIDE_W = 16,
    parameter int WORDS  = 64,
    parameter int WAW    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              wr_all_i,
    input  logic              wide_i,
    input  logic [WAW:0]      wr_addr_i,
    input  logic [WIDE_W-1:0] wr_data_i,
    input  logic [WAW:0]      rd_addr_i,
    output logic [WIDE_W-1:0] rd_data_o
);

    localparam int HALF = WIDE_W / 2;

    logic [WIDE_W-1:0] words [WORDS];
    logic [WAW-1:0]    wr_word;
    logic [WAW-1:0]    rd_word;
    logic [WIDE_W-1:0] fill_pat;
    logic [WIDE_W-1:0] rd_sel;

    assign wr_word  = wide_i ? wr_addr_i[WAW-1:0] : wr_addr_i[WAW:1];
    assign fill_pat = wide_i ? wr_data_i : {2{wr_data_i[HALF-1:0]}};

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        logic [WIDE_W-1:0] word_q;

        // One storage word: reset to ones, full or half update on a hit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '1;
            end else if (wr_i && (wr_all_i || wr_word == WAW'(i))) begin
                if (wr_all_i || wide_i) begin
                    word_q <= fill_pat;
                end else if (wr_addr_i[0]) begin
                    word_q[WIDE_W-1:HALF] <= wr_data_i[HALF-1:0];
                end else begin
                    word_q[HALF-1:0] <= wr_data_i[HALF-1:0];
                end
            end
        end

        assign words[i] = word_q;
    end

    assign rd_word = wide_i ? rd_addr_i[WAW-1:0] : rd_addr_i[WAW:1];
    assign rd_sel  = words[rd_word];

    // Narrow reads return the selected byte left-aligned for MSB-first shifting.
    always_comb begin
        if (wide_i) begin
            rd_data_o = rd_sel;
        end else if (rd_addr_i[0]) begin
            rd_data_o = {rd_sel[WIDE_W-1:HALF], {HALF{1'b0}}};
        end else begin
            rd_data_o = {rd_sel[HALF-1:0], {HALF{1'b0}}};
        end
    end

endmodule

// File: rtl/nvm_cmd_fsm.sv
// Frame decoder and output shifter. Consumes conditioned chip-select and
// shift-clock events, decodes start bit, opcode, address and data, keeps the
// programming-enable latch, issues programming requests and drives the serial
// output (read data or busy/ready). Assumes the width input is static per frame.
module nvm_cmd_fsm
    import nvm_pkg::*;
#(
    parameter int WIDE_W = 16,
    parameter int WAW    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_lvl_i,
    input  logic              cs_rise_i,
    input  logic              sk_rise_i,
    input  logic              di_i,
    input  logic              wide_i,
    input  logic              busy_i,
    input  logic [WIDE_W-1:0] rd_data_i,
    output logic [WAW:0]      rd_addr_o,
    output logic              prog_start_o,
    output logic              prog_all_o,
    output logic [WAW:0]      prog_addr_o,
    output logic [WIDE_W-1:0] prog_data_o,
    output logic              wen_o,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic              st_read_o,
    output logic              st_status_o
);

    localparam int NAW  = WAW + 1;
    localparam int HALF = WIDE_W / 2;
    localparam int CW   = $clog2(WIDE_W + 1);

    fsm_state_t        state_q;
    logic [CW-1:0]     cnt_q;
    logic [1:0]        op_q;
    logic [NAW-1:0]    addr_q;
    logic [WIDE_W-1:0] din_q;
    logic [WIDE_W-1:0] dout_q;
    logic              sdo_q;
    logic              wen_q;
    logic              start_q;
    logic              all_q;
    logic [WIDE_W-1:0] pdata_q;

    logic [NAW-1:0]    addr_next;
    logic [WIDE_W-1:0] din_next;
    logic [1:0]        sub_cmd;
    logic [CW-1:0]     adr_last;
    logic [CW-1:0]     dat_last;
    logic [CW-1:0]     dat_len;

    assign addr_next = {addr_q[NAW-2:0], di_i};
    assign din_next  = {din_q[WIDE_W-2:0], di_i};
    assign sub_cmd   = wide_i ? addr_next[WAW-1 -: 2] : addr_next[WAW -: 2];
    assign adr_last  = wide_i ? CW'(WAW - 1) : CW'(WAW);
    assign dat_last  = wide_i ? CW'(WIDE_W - 1) : CW'(HALF - 1);
    assign dat_len   = wide_i ? CW'(WIDE_W) : CW'(HALF);

    // Frame sequencing, enable latch and programming-request generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            op_q    <= '0;
            addr_q  <= '0;
            din_q   <= '0;
            dout_q  <= '0;
            sdo_q   <= 1'b0;
            wen_q   <= 1'b0;
            start_q <= 1'b0;
            all_q   <= 1'b0;
            pdata_q <= '0;
        end else begin
            start_q <= 1'b0;
            if (!cs_lvl_i) begin
                state_q <= S_IDLE;
            end else if (cs_rise_i) begin
                state_q <= busy_i ? S_STAT : S_START;
            end else if (sk_rise_i) begin
                case (state_q)
                    S_START: begin
                        if (di_i) begin
                            state_q <= S_OPC;
                            cnt_q   <= '0;
                        end
                    end
                    S_OPC: begin
                        op_q <= {op_q[0], di_i};
                        if (cnt_q == CW'(1)) begin
                            state_q <= S_ADR;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                    S_ADR: begin
                        addr_q <= addr_next;
                        if (cnt_q == adr_last) begin
                            cnt_q <= '0;
                            case (op_q)
                                OPC_READ: begin
                                    state_q <= S_RD;
                                    sdo_q   <= 1'b0;
                                    dout_q  <= rd_data_i;
                                end
                                OPC_WRITE: state_q <= S_DAT;
                                OPC_ERASE: begin
                                    state_q <= S_DONE;
                                    start_q <= wen_q;
                                    all_q   <= 1'b0;
                                    pdata_q <= '1;
                                end
                                default: begin
                                    state_q <= S_DONE;
                                    case (sub_cmd)
                                        SUB_ENABLE:  wen_q <= 1'b1;
                                        SUB_DISABLE: wen_q <= 1'b0;
                                        SUB_CLEAR: begin
                                            start_q <= wen_q;
                                            all_q   <= 1'b1;
                                            pdata_q <= '1;
                                        end
                                        default: state_q <= S_DAT;
                                    endcase
                                end
                            endcase
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                    S_DAT: begin
                        din_q <= din_next;
                        if (cnt_q == dat_last) begin
                            state_q <= S_DONE;
                            start_q <= wen_q;
                            all_q   <= (op_q == OPC_SPECIAL);
                            pdata_q <= din_next;
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                    S_RD: begin
                        if (cnt_q == dat_len) begin
                            state_q <= S_DONE;
                        end else begin
                            sdo_q  <= dout_q[WIDE_W-1];
                            dout_q <= {dout_q[WIDE_W-2:0], 1'b0};
                            cnt_q  <= cnt_q + CW'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_addr_o    = addr_next;
    assign prog_start_o = start_q;
    assign prog_all_o   = all_q;
    assign prog_addr_o  = addr_q;
    assign prog_data_o  = pdata_q;
    assign wen_o        = wen_q;
    assign st_read_o    = (state_q == S_RD);
    assign st_status_o  = (state_q == S_STAT);
    assign sdo_oe_o     = st_read_o | st_status_o;
    assign sdo_o        = st_status_o ? ~busy_i : sdo_q;

endmodule

// File: rtl/serial_nvm_slave.sv
// Top of the three-wire serial EEPROM model: input conditioner, frame decoder,
// programming timer and storage array. The width select is assumed static.
module serial_nvm_slave #(
    parameter int MEM_BITS    = 1024,
    parameter int WIDE_W      = 16,
    parameter int PROG_CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    input  logic wide_i,
    output logic sdo_o,
    output logic sdo_oe_o
);

    localparam int WORDS = MEM_BITS / WIDE_W;
    localparam int WAW   = $clog2(WORDS);

    logic              cs_lvl;
    logic              cs_rise;
    logic              sk_rise;
    logic              di_lvl;
    logic              busy;
    logic              prog_start;
    logic              prog_all;
    logic              wen;
    logic              st_read;
    logic              st_status;
    logic [WAW:0]      rd_addr;
    logic [WAW:0]      prog_addr;
    logic [WIDE_W-1:0] rd_data;
    logic [WIDE_W-1:0] prog_data;

    nvm_in_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_i      (cs_i),
        .sk_i      (sk_i),
        .di_i      (di_i),
        .cs_lvl_o  (cs_lvl),
        .cs_rise_o (cs_rise),
        .sk_rise_o (sk_rise),
        .di_lvl_o  (di_lvl)
    );

    nvm_cmd_fsm #(.WIDE_W(WIDE_W), .WAW(WAW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_lvl_i     (cs_lvl),
        .cs_rise_i    (cs_rise),
        .sk_rise_i    (sk_rise),
        .di_i         (di_lvl),
        .wide_i       (wide_i),
        .busy_i       (busy),
        .rd_data_i    (rd_data),
        .rd_addr_o    (rd_addr),
        .prog_start_o (prog_start),
        .prog_all_o   (prog_all),
        .prog_addr_o  (prog_addr),
        .prog_data_o  (prog_data),
        .wen_o        (wen),
        .sdo_o        (sdo_o),
        .sdo_oe_o     (sdo_oe_o),
        .st_read_o    (st_read),
        .st_status_o  (st_status)
    );

    nvm_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (prog_start),
        .busy_o  (busy)
    );

    nvm_array #(.WIDE_W(WIDE_W), .WORDS(WORDS), .WAW(WAW)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (prog_start),
        .wr_all_i  (prog_all),
        .wide_i    (wide_i),
        .wr_addr_i (prog_addr),
        .wr_data_i (prog_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );

endmodule

// File: rtl/nvm_checker.sv
// Protocol checker for serial_nvm_slave, attached by bind. Observes the
// conditioned chip select, the enable latch, the timer and the output pins.
module nvm_checker (
    input logic clk,
    input logic rst_n,
    input logic cs_lvl,
    input logic busy,
    input logic prog_start,
    input logic wen,
    input logic st_read,
    input logic st_status,
    input logic sdo,
    input logic sdo_oe
);

    a_r10_release_when_deselected: assert property (
        @(posedge clk) disable iff (!rst_n) !cs_lvl |=> !sdo_oe);

    a_r4_prog_needs_enable: assert property (
        @(posedge clk) disable iff (!rst_n) $rose(busy) |-> wen);

    a_r9_no_start_while_busy: assert property (
        @(posedge clk) disable iff (!rst_n) busy |-> !prog_start);

    a_r8_ready_holds: assert property (
        @(posedge clk) disable iff (!rst_n)
        (st_status && $past(st_status) && $past(sdo)) |-> sdo);

    a_r3_dummy_first: assert property (
        @(posedge clk) disable iff (!rst_n) ($rose(sdo_oe) && st_read) |-> !sdo);

endmodule

bind serial_nvm_slave nvm_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_lvl     (cs_lvl),
    .busy       (busy),
    .prog_start (prog_start),
    .wen        (wen),
    .st_read    (st_read),
    .st_status  (st_status),
    .sdo        (sdo_o),
    .sdo_oe     (sdo_oe_o)
);

// File: tb/tb_serial_nvm_slave.sv
module tb_serial_nvm_slave;

    localparam int PROG = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0;
    logic sk = 1'b0;
    logic di = 1'b0;
    logic wide = 1'b1;
    logic sdo;
    logic oe;

    int n_chk = 0;
    int n_fail = 0;
    int cs_low_run = 0;
    bit done = 1'b0;

    logic [7:0] model_mem [128];
    bit model_wen = 1'b0;

    always #5 clk = ~clk;

    serial_nvm_slave #(.PROG_CYCLES(PROG)) dut (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
        .wide_i(wide), .sdo_o(sdo), .sdo_oe_o(oe)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // R10: every clock, once chip select has been low long enough, the pad is released
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cs_low_run = cs ? 0 : cs_low_run + 1;
            if (cs_low_run >= 4) check("R10", "oe while deselected", 32'(oe), 32'd0);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        di = b; tick(2); sk = 1'b1; tick(4); sk = 1'b0; tick(2);
    endtask

    task automatic sel();
        cs = 1'b1; tick(4);
    endtask

    task automatic desel();
        cs = 1'b0; di = 1'b0; tick(6);
    endtask

    function automatic int aw();
        return wide ? 6 : 7;
    endfunction

    function automatic int dw();
        return wide ? 16 : 8;
    endfunction

    task automatic head(input logic [1:0] opc, input int addr);
        bit_out(1'b1); bit_out(opc[1]); bit_out(opc[0]);
        for (int i = aw() - 1; i >= 0; i--) bit_out(((addr >> i) & 1) != 0);
    endtask

    task automatic data_out(input int d);
        for (int i = dw() - 1; i >= 0; i--) bit_out(((d >> i) & 1) != 0);
    endtask

    function automatic int model_read(input int a);
        if (wide) return {16'h0, model_mem[2*a+1], model_mem[2*a]};
        return {24'h0, model_mem[a]};
    endfunction

    function automatic void model_store(input int a, input int d);
        if (wide) begin
            model_mem[2*a]   = d[7:0];
            model_mem[2*a+1] = d[15:8];
        end else begin
            model_mem[a] = d[7:0];
        end
    endfunction

    // status window after a command: busy then ready, then no status on a later select
    task automatic status_window(input bit expect_prog, input string req);
        int waited;
        sel();
        if (expect_prog) begin
            check("R8", "status oe", 32'(oe), 32'd1);
            check("R8", "busy flag", 32'(sdo), 32'd0);
            waited = 0;
            while (sdo !== 1'b1 && waited < PROG + 50) begin tick(1); waited++; end
            check("R8", "ready flag", 32'(sdo), 32'd1);
            check("R8", "interval length", 32'(waited > PROG - 40), 32'd1);
            desel();
            sel();
            check("R8", "no status after ready", 32'(oe), 32'd0);
        end else begin
            check(req, "no busy when not programming", 32'(oe), 32'd0);
        end
        desel();
    endtask

    task automatic read_chk(input int a, input string req);
        int exp;
        exp = model_read(a);
        sel();
        head(2'b10, a);
        check("R3", "dummy enable", 32'(oe), 32'd1);
        check("R3", "dummy zero", 32'(sdo), 32'd0);
        for (int k = dw() - 1; k >= 0; k--) begin
            bit_out(1'b0);
            check(req, $sformatf("read a=%0d bit%0d", a, k), 32'(sdo), 32'((exp >> k) & 1));
        end
        bit_out(1'b0);
        check("R3", "release after last bit", 32'(oe), 32'd0);
        desel();
    endtask

    task automatic do_write(input int a, input int d, input string req);
        sel(); head(2'b01, a); data_out(d); desel();
        if (model_wen) model_store(a, d);
        status_window(model_wen, req);
    endtask

    task automatic do_erase(input int a, input string req);
        sel(); head(2'b11, a); desel();
        if (model_wen) model_store(a, 32'hFFFF);
        status_window(model_wen, req);
    endtask

    task automatic do_special(input logic [1:0] sub, input int junk, input int d, input string req);
        int a;
        a = (int'(sub) << (aw() - 2)) | (junk & ((1 << (aw() - 2)) - 1));
        sel(); head(2'b00, a);
        if (sub == 2'b01) data_out(d);
        desel();
        case (sub)
            2'b11: model_wen = 1'b1;
            2'b00: model_wen = 1'b0;
            2'b10: if (model_wen) foreach (model_mem[i]) model_mem[i] = 8'hFF;
            default: if (model_wen) begin
                for (int i = 0; i < 128; i++)
                    model_mem[i] = (wide && i[0]) ? d[15:8] : d[7:0];
            end
        endcase
        if (sub == 2'b10 || sub == 2'b01) status_window(model_wen, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        foreach (model_mem[i]) model_mem[i] = 8'hFF;
        tick(5);
        rst_n = 1'b1;
        tick(2);
        check("R4", "reset oe", 32'(oe), 32'd0);

        // disabled after reset: write ignored, read still works (R4, R3)
        wide = 1'b1;
        do_write(5, 16'h1234, "R4");
        read_chk(5, "R4");

        // enable with nonzero don't-care bits (R2), then word write (R1, R5)
        do_special(2'b11, 4'b1010, 0, "R2");
        do_write(5, 16'hA5C3, "R5");
        read_chk(5, "R1");
        wide = 1'b0;
        read_chk(10, "R5");
        read_chk(11, "R5");

        // narrow write at the top byte, seen through a wide read (R5)
        do_write(127, 8'h3C, "R5");
        wide = 1'b1;
        read_chk(63, "R5");

        // single erase (R6)
        do_erase(5, "R6");
        read_chk(5, "R6");

        // narrow write-all (R7)
        wide = 1'b0;
        do_special(2'b01, 5'b10101, 8'h5A, "R7");
        wide = 1'b1;
        read_chk(0, "R7");
        read_chk(40, "R7");
        do_special(2'b01, 0, 16'hC0DE, "R7");
        read_chk(17, "R7");

        // erase all (R6)
        do_special(2'b10, 3, 0, "R6");
        read_chk(33, "R6");

        // traffic in a window opened while busy is ignored (R9)
        sel(); head(2'b01, 1); data_out(16'h1111); desel();
        model_store(1, 16'h1111);
        sel();
        check("R9", "busy window oe", 32'(oe), 32'd1);
        head(2'b01, 2); data_out(16'h2222);
        check("R9", "still in status", 32'(oe), 32'd1);
        while (sdo !== 1'b1) tick(1);
        desel();
        read_chk(2, "R9");
        read_chk(1, "R5");

        // disable, then programming is ignored (R4)
        do_special(2'b00, 0, 0, "R2");
        do_write(3, 16'h0F0F, "R4");
        do_erase(1, "R4");
        read_chk(3, "R4");
        read_chk(1, "R4");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule